// File: doc/BRIEF.md
# Device Configuration Sequencer

This unit sits between a processor bus and a programmable target device that is being loaded with a bitstream. Software sees two 32-bit registers. A control register sets the device's chip-enable and configuration-reset lines, the width of the data path toward the device and how many clocks each data unit is held. A status register reports the device's mode-select strapping and a 3-bit phase. The unit works out that phase from its own reset pulling and from the device's handshake lines.

Software first pulses the configuration reset and waits for the configuration phase. It then opens the data path and writes configuration words to a separate data port. Each accepted word is pushed to the device as one 32-bit unit, or as two 16-bit halves. Each unit is held for 1, 2, 4 or 8 clocks. The phase then moves through initialisation to user mode as the device reports completion. If the device flags an error, the phase goes to an unknown state and stays there.

Top module: `devcfg_ctrl`

## Requirements
- R1: After synchronous reset the control register reads 0, the phase reads 0, `dev_nconfig` is 1, `dev_nce` is 0 and `dev_dvalid` is 0.
- R2: The status register (byte offset 0x0) reads the phase in bits [2:0] and `dev_msel` in bits [7:3], with all other bits 0. Writes to it change no register.
- R3: The control register (byte offset 0x4) stores enable (bit 0), active-low chip enable (bit 1), reset pull (bit 2), ratio (bits [7:6]), transfer enable (bit 8) and width (bit 9). All other bits read 0. `dev_nce` follows bit 1.
- R4: `dev_nconfig` is low exactly while bits 0 and 2 are both set. While it is low the phase reads 1 (reset). One cycle after release the phase becomes 2 (configuration).
- R5: In phase 2, `dev_conf_done` high with `dev_nstatus` high moves the phase to 3 (initialisation). In phase 3, `dev_init_done` high moves it to 4 (user mode).
- R6: `dev_nstatus` low in phase 2 or 3 moves the phase to 5 (unknown). The phase stays at 5 until the next reset pull.
- R7: While `dev_pwr_good` is low the phase reads 0 in the same cycle, and the tracker returns to 0. With power restored the phase stays 0 until a reset pull.
- R8: A data-port write is accepted only when control bits 0 and 8 are both set and no word is being emitted. Otherwise it produces no output.
- R9: In 32-bit mode (bit 9 = 1) an accepted word appears on `dev_data` with `dev_dvalid` high for 1, 2, 4 or 8 cycles (ratio 00, 01, 10, 11). Output starts in the cycle after acceptance. `dev_data` is 0 whenever `dev_dvalid` is low.
- R10: In 16-bit mode (bit 9 = 0) the low half is emitted first and then the high half. Each half is held for the ratio's cycle count, and bits [31:16] of `dev_data` stay 0.
- R11: Width and ratio are captured when a word is accepted. Control writes during emission do not alter that word's output, and data-port writes during emission are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid the cycle after `bus_rd` |
| dat_wr | input | 1 | Configuration data write strobe |
| dat_word | input | 32 | Configuration data word |
| dev_msel | input | 5 | Device mode-select strapping |
| dev_pwr_good | input | 1 | Device power monitor, high when powered |
| dev_nstatus | input | 1 | Device status, low on error or reset |
| dev_conf_done | input | 1 | Device reports bitstream received |
| dev_init_done | input | 1 | Device reports initialisation complete |
| dev_nconfig | output | 1 | Device configuration reset, active low |
| dev_nce | output | 1 | Device chip enable, active low |
| dev_data | output | 32 | Data unit toward the device |
| dev_dvalid | output | 1 | High while a data unit is presented |

## Verification
Register read data is due one cycle after the read strobe. The phase register takes a handshake or control change at the next edge. The bench therefore lets one idle cycle pass after every input change or register write before it issues a read. The first data unit is due the cycle after the accepting edge, and each unit lasts the ratio's cycle count. The driver queues one expected value per output cycle. A monitor pops and compares on every falling edge where `dev_dvalid` is high, and it counts any unqueued output as a failure. Dropped words are therefore caught as extra cycles once the queue has drained.

// File: rtl/devcfg_pkg.sv
package devcfg_pkg;
    localparam int REG_W  = 32;
    localparam int PH_W   = 3;
    localparam int RAT_W  = 2;
    localparam int CNT_W  = 3;

    typedef enum logic [PH_W-1:0] {
        PH_PWRUP   = 3'd0,
        PH_RESET   = 3'd1,
        PH_CONFIG  = 3'd2,
        PH_INIT    = 3'd3,
        PH_USER    = 3'd4,
        PH_UNKNOWN = 3'd5
    } phase_e;

    typedef struct packed {
        logic             wide;
        logic             xfer;
        logic [RAT_W-1:0] ratio;
        logic             pull;
        logic             nce;
        logic             en;
    } ctrl_t;

    function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.en    = w[0];
        c.nce   = w[1];
        c.pull  = w[2];
        c.ratio = w[7:6];
        c.xfer  = w[8];
        c.wide  = w[9];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w      = '0;
        w[0]   = c.en;
        w[1]   = c.nce;
        w[2]   = c.pull;
        w[7:6] = c.ratio;
        w[8]   = c.xfer;
        w[9]   = c.wide;
        return w;
    endfunction

    function automatic logic [CNT_W:0] unit_len(input logic [RAT_W-1:0] r);
        return (CNT_W+1)'(1) << r;
    endfunction
endpackage

// File: rtl/devcfg_regs.sv
module devcfg_regs
    import devcfg_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int MSEL_W   = 5,
    parameter int STAT_OFS = 0,
    parameter int CTRL_OFS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [MSEL_W-1:0] msel,
    input  logic [PH_W-1:0]   phase,
    output ctrl_t             ctrl
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam int PAD_W = REG_W - MSEL_W - PH_W;

    logic [REG_W-1:0] rmux;

    always_comb begin
        rmux = '0;
        if (addr == A_STAT)      rmux = {{PAD_W{1'b0}}, msel, phase};
        else if (addr == A_CTRL) rmux = ctrl_to_word(ctrl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            rdata <= '0;
        end else begin
            if (wr && addr == A_CTRL) ctrl <= word_to_ctrl(wdata);
            if (rd) rdata <= rmux;
        end
    end
endmodule

// File: rtl/devcfg_phase.sv
module devcfg_phase
    import devcfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            pulled,
    input  logic            pwr_good,
    input  logic            nstatus,
    input  logic            conf_done,
    input  logic            init_done,
    output phase_e          phase_q,
    output logic [PH_W-1:0] phase_rep
);
    always_ff @(posedge clk) begin
        if (rst || !pwr_good) begin
            phase_q <= PH_PWRUP;
        end else if (pulled) begin
            phase_q <= PH_RESET;
        end else begin
            unique case (phase_q)
                PH_RESET:  phase_q <= PH_CONFIG;
                PH_CONFIG: if (!nstatus)       phase_q <= PH_UNKNOWN;
                           else if (conf_done) phase_q <= PH_INIT;
                PH_INIT:   if (!nstatus)       phase_q <= PH_UNKNOWN;
                           else if (init_done) phase_q <= PH_USER;
                default:   phase_q <= phase_q;
            endcase
        end
    end

    assign phase_rep = pwr_good ? phase_q : PH_PWRUP;
endmodule

// File: rtl/devcfg_ser.sv
module devcfg_ser
    import devcfg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] word,
    input  logic              wide,
    input  logic [RAT_W-1:0]  ratio,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid
);
    localparam int HALF = DATA_W / 2;

    logic              busy, half, wide_q;
    logic [RAT_W-1:0]  ratio_q;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] word_q;
    logic              last_tick;

    assign last_tick = ({1'b0, cnt} == unit_len(ratio_q) - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            half    <= 1'b0;
            wide_q  <= 1'b0;
            ratio_q <= '0;
            cnt     <= '0;
            word_q  <= '0;
        end else if (!busy) begin
            if (take) begin
                busy    <= 1'b1;
                half    <= 1'b0;
                cnt     <= '0;
                word_q  <= word;
                wide_q  <= wide;
                ratio_q <= ratio;
            end
        end else if (last_tick) begin
            cnt <= '0;
            if (wide_q || half) busy <= 1'b0;
            else                half <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        dout = '0;
        if (busy) begin
            if (wide_q)    dout = word_q;
            else if (half) dout = {{HALF{1'b0}}, word_q[DATA_W-1:HALF]};
            else           dout = {{HALF{1'b0}}, word_q[HALF-1:0]};
        end
    end

    assign dvalid = busy;
endmodule

// File: rtl/devcfg_ctrl.sv
module devcfg_ctrl
    import devcfg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int MSEL_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_word,
    input  logic [MSEL_W-1:0] dev_msel,
    input  logic              dev_pwr_good,
    input  logic              dev_nstatus,
    input  logic              dev_conf_done,
    input  logic              dev_init_done,
    output logic              dev_nconfig,
    output logic              dev_nce,
    output logic [DATA_W-1:0] dev_data,
    output logic              dev_dvalid
);
    ctrl_t           ctrl;
    phase_e          phase_q;
    logic [PH_W-1:0] phase_rep;
    logic            pulled;

    assign pulled      = ctrl.en & ctrl.pull;
    assign dev_nconfig = ~pulled;
    assign dev_nce     = ctrl.nce;

    devcfg_regs #(.ADDR_W(ADDR_W), .MSEL_W(MSEL_W)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .msel(dev_msel),
        .phase(phase_rep), .ctrl(ctrl)
    );

    devcfg_phase u_phase (
        .clk(clk), .rst(rst), .pulled(pulled), .pwr_good(dev_pwr_good),
        .nstatus(dev_nstatus), .conf_done(dev_conf_done),
        .init_done(dev_init_done), .phase_q(phase_q), .phase_rep(phase_rep)
    );

    devcfg_ser #(.DATA_W(DATA_W)) u_ser (
        .clk(clk), .rst(rst), .take(dat_wr & ctrl.en & ctrl.xfer),
        .word(dat_word), .wide(ctrl.wide), .ratio(ctrl.ratio),
        .dout(dev_data), .dvalid(dev_dvalid)
    );
endmodule

// File: rtl/devcfg_ctrl_chk.sv
module devcfg_ctrl_chk
    import devcfg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              dev_nconfig,
    input logic              dev_pwr_good,
    input logic [PH_W-1:0]   phase_q,
    input logic              dev_dvalid,
    input logic [DATA_W-1:0] dev_data,
    input logic              dat_wr,
    input logic              en,
    input logic              xfer
);
    p_pull_reset_r4: assert property (@(posedge clk) disable iff (rst)
        (!dev_nconfig && dev_pwr_good) |=> phase_q == PH_RESET);

    p_unknown_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_UNKNOWN && dev_nconfig && dev_pwr_good) |=> phase_q == PH_UNKNOWN);

    p_power_loss_r7: assert property (@(posedge clk) disable iff (rst)
        !dev_pwr_good |=> phase_q == PH_PWRUP);

    p_gated_start_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_dvalid) |-> $past(dat_wr && en && xfer));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !dev_dvalid |-> dev_data == '0);
endmodule

bind devcfg_ctrl devcfg_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .dev_nconfig(dev_nconfig), .dev_pwr_good(dev_pwr_good),
    .phase_q(phase_q), .dev_dvalid(dev_dvalid), .dev_data(dev_data),
    .dat_wr(dat_wr), .en(ctrl.en), .xfer(ctrl.xfer)
);

// File: tb/devcfg_ctrl_tb.sv
module devcfg_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 0, bus_rd = 0, dat_wr = 0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, dat_word = '0, dev_data;
    logic [4:0]  dev_msel = 5'h13;
    logic        dev_pwr_good = 1, dev_nstatus = 1, dev_conf_done = 0, dev_init_done = 0;
    logic        dev_nconfig, dev_nce, dev_dvalid;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_q[$];
    string cur_tag = "R9";

    always #10 clk = ~clk;

    devcfg_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dat_wr(dat_wr), .dat_word(dat_word),
        .dev_msel(dev_msel), .dev_pwr_good(dev_pwr_good), .dev_nstatus(dev_nstatus),
        .dev_conf_done(dev_conf_done), .dev_init_done(dev_init_done),
        .dev_nconfig(dev_nconfig), .dev_nce(dev_nce), .dev_data(dev_data),
        .dev_dvalid(dev_dvalid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
        @(negedge clk);
    endtask

    task automatic reg_rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        chk(tag, bus_rdata, exp);
    endtask

    function automatic logic [31:0] stat(input logic [2:0] ph);
        return {24'h0, dev_msel, ph};
    endfunction

    // Driver: queues the expected units, then strobes the data port once.
    task automatic send(input logic [31:0] w, input bit ok, input bit wide, input int ratio);
        if (ok) begin
            for (int u = 0; u < (wide ? 1 : 2); u++)
                for (int k = 0; k < (1 << ratio); k++)
                    exp_q.push_back(wide ? w : (u == 0 ? {16'h0, w[15:0]} : {16'h0, w[31:16]}));
        end
        dat_wr = 1; dat_word = w;
        @(negedge clk);
        dat_wr = 0;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 200 && (exp_q.size() != 0 || dev_dvalid); i++) @(negedge clk);
        tick(3);
        chk({tag, " queue drained"}, 32'(exp_q.size()), 32'd0);
    endtask

    // Monitor: one comparison per output cycle.
    always @(negedge clk) begin
        if (!rst && dev_dvalid) begin
            if (exp_q.size() == 0) chk({cur_tag, " unexpected unit"}, dev_data, 32'hxxxx_xxxx);
            else chk({cur_tag, " unit"}, dev_data, exp_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        // R1 reset state
        chk("R1 nconfig", {31'h0, dev_nconfig}, 32'd1);
        chk("R1 nce", {31'h0, dev_nce}, 32'd0);
        chk("R1 dvalid", {31'h0, dev_dvalid}, 32'd0);
        reg_rd("R1 ctrl", 4'h4, 32'h0);
        reg_rd("R1 stat", 4'h0, stat(3'd0));
        // R2 status write ignored
        reg_wr(4'h0, 32'hFFFF_FFFF);
        reg_rd("R2 ctrl unchanged", 4'h4, 32'h0);
        reg_rd("R2 stat layout", 4'h0, stat(3'd0));
        dev_msel = 5'h0A; tick(1);
        reg_rd("R2 msel follows", 4'h0, stat(3'd0));
        // R3 field storage, R4 pull
        reg_wr(4'h4, 32'hFFFF_FFFF);
        reg_rd("R3 ctrl fields", 4'h4, 32'h0000_03C7);
        chk("R3 nce", {31'h0, dev_nce}, 32'd1);
        chk("R4 nconfig low", {31'h0, dev_nconfig}, 32'd0);
        reg_rd("R4 phase reset", 4'h0, stat(3'd1));
        reg_wr(4'h4, 32'h0000_0004);
        chk("R4 pull without enable", {31'h0, dev_nconfig}, 32'd1);
        reg_rd("R4 phase config", 4'h0, stat(3'd2));
        // R5 progression
        dev_conf_done = 1; tick(1);
        reg_rd("R5 phase init", 4'h0, stat(3'd3));
        dev_init_done = 1; tick(1);
        reg_rd("R5 phase user", 4'h0, stat(3'd4));
        dev_conf_done = 0; dev_init_done = 0;
        // R6 error
        reg_wr(4'h4, 32'h5);
        reg_rd("R4 pull again", 4'h0, stat(3'd1));
        reg_wr(4'h4, 32'h1);
        reg_rd("R4 release", 4'h0, stat(3'd2));
        dev_nstatus = 0; tick(1);
        reg_rd("R6 unknown", 4'h0, stat(3'd5));
        dev_nstatus = 1; tick(2);
        reg_rd("R6 unknown held", 4'h0, stat(3'd5));
        reg_wr(4'h4, 32'h5);
        reg_rd("R6 cleared by pull", 4'h0, stat(3'd1));
        reg_wr(4'h4, 32'h1);
        // R7 power
        dev_pwr_good = 0;
        #1;
        reg_rd("R7 forced zero", 4'h0, stat(3'd0));
        dev_pwr_good = 1; tick(2);
        reg_rd("R7 stays zero", 4'h0, stat(3'd0));
        reg_wr(4'h4, 32'h5);
        reg_rd("R7 restart", 4'h0, stat(3'd1));
        // R9 wide mode, ratios x1 and x4
        cur_tag = "R9";
        reg_wr(4'h4, 32'h0000_0301);
        send(32'hDEAD_BEEF, 1, 1, 0); drain("R9 x1");
        reg_wr(4'h4, 32'h0000_0381);
        send(32'h1234_5678, 1, 1, 2); drain("R9 x4");
        // R10 narrow mode x2 and x8
        cur_tag = "R10";
        reg_wr(4'h4, 32'h0000_0141);
        send(32'hA5A5_3C3C, 1, 0, 1); drain("R10 x2");
        reg_wr(4'h4, 32'h0000_01C1);
        send(32'h0F0F_F0F0, 1, 0, 3); drain("R10 x8");
        // R8 gating
        cur_tag = "R8";
        reg_wr(4'h4, 32'h0000_0201);
        send(32'h1111_1111, 0, 1, 0); drain("R8 no xfer");
        reg_wr(4'h4, 32'h0000_0300);
        send(32'h2222_2222, 0, 1, 0); drain("R8 no enable");
        // R11 capture and drop during emission
        cur_tag = "R11";
        reg_wr(4'h4, 32'h0000_03C1);
        send(32'hCAFE_F00D, 1, 1, 3);
        send(32'h3333_3333, 0, 1, 3);
        reg_wr(4'h4, 32'h0000_0101);
        drain("R11 captured settings");
        send(32'h4444_5555, 1, 0, 0); drain("R11 new settings");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule